// File: doc/BRIEF.md
# Clock-Ratio Bus Cycle Bridge

The bridge sits between a processor that runs its multiplexed 64-bit address/data bus at a fast clock and a board that runs the same bus protocol at a slower clock, two or three times slower. Each beat the processor strobes is taken at the fast clock. It is given parity where the processor supplies none and placed in a dual-clock queue. The board-side issue stage then replays it at the board clock. Read requests that the secondary cache already satisfied are never queued. Read data coming back from the board passes through a second dual-clock queue to the processor.

On the return path the bridge watches a bad-data flag in the command of each data beat. From a flagged beat to the end of its four-beat burst, the check bits handed to the processor are inverted, so the processor sees a parity error on every beat of the burst that is no longer trustworthy. The processor-side command parity output stays at zero. The command parity inputs on both sides are ignored.

Command encoding used throughout: bit 8 = 0 marks an address beat and bit 8 = 1 marks a data beat. On an address beat, bit 7 = 1 means write and bit 7 = 0 means read. On a data beat, bit 5 = 1 means the data is bad.

Top module: `clock_ratio_bridge`

## Requirements
- R1: Every processor beat accepted into the queue appears on the board bus exactly once, in acceptance order, with its address/data and command unchanged, qualified by `brd_valid_o`.
- R2: On an address beat (cmd bit 8 = 0), board check bit i is the even parity (XOR) of byte i of the bus, byte 0 being bits 7:0. On a write data beat, the processor's check bits pass through unchanged.
- R3: `brd_cmdpar_o` equals the XOR of the nine command bits of the beat it accompanies. `cpu_cmdpar_o` is always 0. `cpu_cmdpar_i` and `brd_cmdpar_i` have no effect on any output.
- R4: A read address beat (cmd bits 8:7 = 00) presented with `cpu_hit_i` high is discarded and never reaches the board bus.
- R5: A read address beat is issued only at a board clock edge where `brd_rd_rdy_i` is high. Write address and write data beats are issued only where `brd_wr_rdy_i` is high. A blocked head beat holds back every later beat.
- R6: `cpu_full_o` is high once the queue holds its full depth (8 beats by default) of unissued beats. A beat strobed while it is high is dropped.
- R7: Every beat strobed by `brd_valid_i` is delivered to the processor in order on `cpu_valid_o`, with address/data and command unchanged.
- R8: A returned data beat with cmd bit 5 set has its check bits inverted toward the processor. So does every later data beat of the same four-beat burst. The burst after it is unaffected unless it carries its own flag.
- R9: After reset, `cpu_valid_o`, `brd_valid_o` and `cpu_full_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side bus clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| cpu_valid_i | input | 1 | Processor drives a valid beat |
| cpu_ad_i | input | 64 | Processor address/data |
| cpu_chk_i | input | 8 | Processor check bits (used on data beats) |
| cpu_cmd_i | input | 9 | Processor command |
| cpu_cmdpar_i | input | 1 | Processor command parity (ignored) |
| cpu_hit_i | input | 1 | Current read was satisfied by the secondary cache |
| cpu_full_o | output | 1 | Outbound queue full, hold off new beats |
| cpu_valid_o | output | 1 | Return beat to processor is valid |
| cpu_ad_o | output | 64 | Return address/data |
| cpu_chk_o | output | 8 | Return check bits, inverted after a bad-data flag |
| cpu_cmd_o | output | 9 | Return command |
| cpu_cmdpar_o | output | 1 | Return command parity, held at zero |
| brd_clk | input | 1 | Board-side bus clock |
| brd_rst | input | 1 | Synchronous active-high reset, board domain |
| brd_rd_rdy_i | input | 1 | Board can take a read request |
| brd_wr_rdy_i | input | 1 | Board can take write beats |
| brd_valid_o | output | 1 | Issued beat is valid |
| brd_ad_o | output | 64 | Issued address/data |
| brd_chk_o | output | 8 | Issued check bits |
| brd_cmd_o | output | 9 | Issued command |
| brd_cmdpar_o | output | 1 | Issued command parity |
| brd_valid_i | input | 1 | Board drives a valid return beat |
| brd_ad_i | input | 64 | Return address/data from board |
| brd_chk_i | input | 8 | Return check bits from board |
| brd_cmd_i | input | 9 | Return command from board |
| brd_cmdpar_i | input | 1 | Board command parity (ignored) |

## Verification
Several properties are checked on every cycle. Queue pointers move one Gray bit at a time and freeze while the queue is full or empty. No beat leaves toward the board unless the matching ready was high one edge earlier. The bad-data state sets on a flagged beat, inverts later beats and clears at the fourth beat. Only the bench scenarios show the end-to-end facts. These are the ordering of beats across the clock crossing, the parity values themselves, the removal of cache-hit reads, the drop of a beat strobed while full, and a read that is held back stalling the writes behind it.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;
    localparam int AD_W          = 64;
    localparam int CHK_W         = AD_W / 8;
    localparam int CMD_W         = 9;
    localparam int CMD_DATA_BIT  = 8;
    localparam int CMD_WRITE_BIT = 7;
    localparam int CMD_BAD_BIT   = 5;
    localparam int BURST_BEATS   = 4;

    typedef struct packed {
        logic [AD_W-1:0]  ad;
        logic [CHK_W-1:0] chk;
        logic [CMD_W-1:0] cmd;
        logic             cmdpar;
    } beat_t;

    localparam int BEAT_W = $bits(beat_t);

    typedef enum logic [1:0] {
        KIND_RD_ADDR = 2'd0,
        KIND_WR_ADDR = 2'd1,
        KIND_DATA    = 2'd2
    } beat_kind_e;

    function automatic beat_kind_e kind_of(input logic [CMD_W-1:0] cmd);
        if (cmd[CMD_DATA_BIT])
            return KIND_DATA;
        else if (cmd[CMD_WRITE_BIT])
            return KIND_WR_ADDR;
        else
            return KIND_RD_ADDR;
    endfunction

    function automatic logic [CHK_W-1:0] lane_parity(input logic [AD_W-1:0] ad);
        logic [CHK_W-1:0] p;
        for (int b = 0; b < CHK_W; b++)
            p[b] = ^ad[b*8 +: 8];
        return p;
    endfunction
endpackage

// File: rtl/crb_sync.sv
`timescale 1ns/1ps
module crb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_stage[i-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/crb_afifo.sv
`timescale 1ns/1ps
module crb_afifo #(
    parameter int W      = 8,
    parameter int AW     = 3,
    parameter int STAGES = 2
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         wen,
    input  logic [W-1:0] wdata,
    output logic         wfull,
    input  logic         rclk,
    input  logic         rrst,
    input  logic         ren,
    output logic [W-1:0] rdata,
    output logic         rempty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin_q, wgray_q, rbin_q, rgray_q;
    logic [AW:0]  wgray_s, rgray_s;
    logic [AW:0]  wbin_n, rbin_n;
    logic         push, pop;

    assign push   = wen && !wfull;
    assign pop    = ren && !rempty;
    assign wbin_n = wbin_q + 1'b1;
    assign rbin_n = rbin_q + 1'b1;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (push) begin
            wbin_q  <= wbin_n;
            wgray_q <= wbin_n ^ (wbin_n >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (push) mem[wbin_q[AW-1:0]] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (pop) begin
            rbin_q  <= rbin_n;
            rgray_q <= rbin_n ^ (rbin_n >> 1);
        end
    end

    crb_sync #(.W(AW+1), .STAGES(STAGES)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray_q), .q(wgray_s)
    );
    crb_sync #(.W(AW+1), .STAGES(STAGES)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray_q), .q(rgray_s)
    );

    assign wfull  = (wgray_q == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    assign rempty = (rgray_q == wgray_s);
    assign rdata  = mem[rbin_q[AW-1:0]];

    // R6
    wr_no_overflow_chk: assert property (@(posedge wclk) disable iff (wrst)
        wfull |=> wgray_q == $past(wgray_q));
    // R1
    wr_gray_step_chk: assert property (@(posedge wclk) disable iff (wrst)
        $onehot0(wgray_q ^ $past(wgray_q)));
    // R1
    rd_gray_step_chk: assert property (@(posedge rclk) disable iff (rrst)
        $onehot0(rgray_q ^ $past(rgray_q)));
    // R1
    rd_no_underflow_chk: assert property (@(posedge rclk) disable iff (rrst)
        rempty |=> rgray_q == $past(rgray_q));
endmodule

// File: rtl/crb_issue.sv
`timescale 1ns/1ps
module crb_issue
    import crb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  empty,
    input  beat_t head,
    input  logic  rd_rdy,
    input  logic  wr_rdy,
    output logic  pop,
    output logic  out_valid,
    output beat_t out_beat
);
    beat_kind_e head_kind;

    assign head_kind = kind_of(head.cmd);
    assign pop = !empty && ((head_kind == KIND_RD_ADDR) ? rd_rdy : wr_rdy);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_beat  <= '0;
        end else begin
            out_valid <= pop;
            if (pop) out_beat <= head;
        end
    end

    // R5
    rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && kind_of(out_beat.cmd) == KIND_RD_ADDR) |-> $past(rd_rdy));
    // R5
    wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && kind_of(out_beat.cmd) != KIND_RD_ADDR) |-> $past(wr_rdy));
endmodule

// File: rtl/crb_return.sv
`timescale 1ns/1ps
module crb_return
    import crb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  empty,
    input  beat_t head,
    output logic  pop,
    output logic  out_valid,
    output beat_t out_beat
);
    localparam int CW = $clog2(BURST_BEATS);
    localparam logic [CW-1:0] LAST_IDX = CW'(BURST_BEATS - 1);

    logic [CW-1:0] cnt_q;
    logic          sticky_q;
    logic          head_data, head_bad, bad_now;
    beat_t         fixed;

    assign pop       = !empty;
    assign head_data = (kind_of(head.cmd) == KIND_DATA);
    assign head_bad  = head.cmd[CMD_BAD_BIT];
    assign bad_now   = head_data && (sticky_q || head_bad);

    always_comb begin
        fixed        = head;
        fixed.chk    = head.chk ^ {CHK_W{bad_now}};
        fixed.cmdpar = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            sticky_q  <= 1'b0;
            out_valid <= 1'b0;
            out_beat  <= '0;
        end else begin
            out_valid <= pop;
            if (pop) out_beat <= fixed;
            if (pop && head_data) begin
                if (cnt_q == LAST_IDX) begin
                    cnt_q    <= '0;
                    sticky_q <= 1'b0;
                end else begin
                    cnt_q    <= cnt_q + 1'b1;
                    sticky_q <= bad_now;
                end
            end
        end
    end

    // R8
    burst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && head_data && cnt_q == LAST_IDX) |=> !sticky_q);
    // R8
    bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && head_data && head_bad && cnt_q != LAST_IDX) |=> sticky_q);
    // R8
    invert_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && head_data && sticky_q) |=> (out_valid && out_beat.chk == ~$past(head.chk)));
endmodule

// File: rtl/clock_ratio_bridge.sv
`timescale 1ns/1ps
module clock_ratio_bridge
    import crb_pkg::*;
#(
    parameter int OUT_DEPTH_LOG2 = 3,
    parameter int RET_DEPTH_LOG2 = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             cpu_clk,
    input  logic             cpu_rst,
    input  logic             cpu_valid_i,
    input  logic [AD_W-1:0]  cpu_ad_i,
    input  logic [CHK_W-1:0] cpu_chk_i,
    input  logic [CMD_W-1:0] cpu_cmd_i,
    input  logic             cpu_cmdpar_i,
    input  logic             cpu_hit_i,
    output logic             cpu_full_o,
    output logic             cpu_valid_o,
    output logic [AD_W-1:0]  cpu_ad_o,
    output logic [CHK_W-1:0] cpu_chk_o,
    output logic [CMD_W-1:0] cpu_cmd_o,
    output logic             cpu_cmdpar_o,
    input  logic             brd_clk,
    input  logic             brd_rst,
    input  logic             brd_rd_rdy_i,
    input  logic             brd_wr_rdy_i,
    output logic             brd_valid_o,
    output logic [AD_W-1:0]  brd_ad_o,
    output logic [CHK_W-1:0] brd_chk_o,
    output logic [CMD_W-1:0] brd_cmd_o,
    output logic             brd_cmdpar_o,
    input  logic             brd_valid_i,
    input  logic [AD_W-1:0]  brd_ad_i,
    input  logic [CHK_W-1:0] brd_chk_i,
    input  logic [CMD_W-1:0] brd_cmd_i,
    input  logic             brd_cmdpar_i
);
    // Command parity inputs carry no meaning for this bridge.
    logic unused_cmdpar;
    assign unused_cmdpar = cpu_cmdpar_i ^ brd_cmdpar_i;

    // Processor side: attach parity, drop cache-hit reads.
    beat_kind_e in_kind;
    beat_t      in_beat;
    logic       in_push;

    assign in_kind = kind_of(cpu_cmd_i);
    assign in_push = cpu_valid_i && !((in_kind == KIND_RD_ADDR) && cpu_hit_i);

    always_comb begin
        in_beat.ad     = cpu_ad_i;
        in_beat.chk    = (in_kind == KIND_DATA) ? cpu_chk_i : lane_parity(cpu_ad_i);
        in_beat.cmd    = cpu_cmd_i;
        in_beat.cmdpar = ^cpu_cmd_i;
    end

    // Outbound crossing and board-side issue.
    logic  out_pop, out_empty;
    beat_t out_head, brd_beat;

    crb_afifo #(.W(BEAT_W), .AW(OUT_DEPTH_LOG2), .STAGES(SYNC_STAGES)) u_out_q (
        .wclk(cpu_clk), .wrst(cpu_rst), .wen(in_push), .wdata(in_beat), .wfull(cpu_full_o),
        .rclk(brd_clk), .rrst(brd_rst), .ren(out_pop), .rdata(out_head), .rempty(out_empty)
    );

    crb_issue u_issue (
        .clk(brd_clk), .rst(brd_rst), .empty(out_empty), .head(out_head),
        .rd_rdy(brd_rd_rdy_i), .wr_rdy(brd_wr_rdy_i),
        .pop(out_pop), .out_valid(brd_valid_o), .out_beat(brd_beat)
    );

    assign brd_ad_o     = brd_beat.ad;
    assign brd_chk_o    = brd_beat.chk;
    assign brd_cmd_o    = brd_beat.cmd;
    assign brd_cmdpar_o = brd_beat.cmdpar;

    // Return crossing and bad-data handling.
    beat_t ret_in, ret_head, cpu_beat;
    logic  ret_full, ret_empty, ret_pop;

    always_comb begin
        ret_in.ad     = brd_ad_i;
        ret_in.chk    = brd_chk_i;
        ret_in.cmd    = brd_cmd_i;
        ret_in.cmdpar = 1'b0;
    end

    crb_afifo #(.W(BEAT_W), .AW(RET_DEPTH_LOG2), .STAGES(SYNC_STAGES)) u_ret_q (
        .wclk(brd_clk), .wrst(brd_rst), .wen(brd_valid_i), .wdata(ret_in), .wfull(ret_full),
        .rclk(cpu_clk), .rrst(cpu_rst), .ren(ret_pop), .rdata(ret_head), .rempty(ret_empty)
    );

    crb_return u_return (
        .clk(cpu_clk), .rst(cpu_rst), .empty(ret_empty), .head(ret_head),
        .pop(ret_pop), .out_valid(cpu_valid_o), .out_beat(cpu_beat)
    );

    assign cpu_ad_o     = cpu_beat.ad;
    assign cpu_chk_o    = cpu_beat.chk;
    assign cpu_cmd_o    = cpu_beat.cmd;
    assign cpu_cmdpar_o = cpu_beat.cmdpar;

    // R7
    ret_room_chk: assert property (@(posedge brd_clk) disable iff (brd_rst)
        brd_valid_i |-> !ret_full);
    // R3
    cpu_cmdpar_zero_chk: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        cpu_valid_o |-> !cpu_cmdpar_o);
endmodule

// File: tb/clock_ratio_bridge_bench.sv
`timescale 1ns/1ps
module clock_ratio_bridge_bench;
    logic cpu_clk = 1'b0;
    logic brd_clk = 1'b0;
    always #2.5 cpu_clk = ~cpu_clk;
    always #7.5 brd_clk = ~brd_clk;

    logic        cpu_rst = 1'b1, brd_rst = 1'b1;
    logic        cpu_valid_i = 1'b0, cpu_cmdpar_i = 1'b0, cpu_hit_i = 1'b0;
    logic [63:0] cpu_ad_i = '0;
    logic [7:0]  cpu_chk_i = '0;
    logic [8:0]  cpu_cmd_i = '0;
    logic        cpu_full_o, cpu_valid_o, cpu_cmdpar_o;
    logic [63:0] cpu_ad_o;
    logic [7:0]  cpu_chk_o;
    logic [8:0]  cpu_cmd_o;
    logic        brd_rd_rdy_i = 1'b0, brd_wr_rdy_i = 1'b0;
    logic        brd_valid_o, brd_cmdpar_o;
    logic [63:0] brd_ad_o;
    logic [7:0]  brd_chk_o;
    logic [8:0]  brd_cmd_o;
    logic        brd_valid_i = 1'b0, brd_cmdpar_i = 1'b0;
    logic [63:0] brd_ad_i = '0;
    logic [7:0]  brd_chk_i = '0;
    logic [8:0]  brd_cmd_i = '0;

    clock_ratio_bridge u_clock_ratio_bridge (.*);

    int checks = 0;
    int fails  = 0;
    int rdy_mode = 0;   // 0 random, 1 both low, 2 read low / write high
    bit finished = 0;
    logic [81:0] exp_brd[$];
    logic [81:0] exp_cpu[$];

    function automatic logic [7:0] ref_par(input logic [63:0] d);
        logic [7:0] p = '0;
        for (int b = 0; b < 8; b++)
            for (int k = 0; k < 8; k++)
                p[b] = p[b] ^ d[8*b + k];
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input logic [81:0] act, input logic [81:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Processor-side beat; expectation follows R2/R3/R4.
    task automatic send_beat(input logic [63:0] ad, input logic [7:0] chk,
                             input logic [8:0] cmd, input bit hit);
        logic [7:0] echk;
        @(negedge cpu_clk);
        while (cpu_full_o) @(negedge cpu_clk);
        cpu_valid_i  = 1'b1;
        cpu_ad_i     = ad;
        cpu_chk_i    = chk;
        cpu_cmd_i    = cmd;
        cpu_hit_i    = hit;
        cpu_cmdpar_i = 1'($urandom);
        echk = cmd[8] ? chk : ref_par(ad);
        if (!(cmd[8:7] == 2'b00 && hit))
            exp_brd.push_back({ad, echk, cmd, ^cmd});
        @(negedge cpu_clk);
        cpu_valid_i = 1'b0;
        cpu_hit_i   = 1'b0;
    endtask

    // Board-side return burst of four data beats; bad flag at bad_pos (>=4 means none). R8.
    task automatic send_burst(input int bad_pos);
        logic [63:0] d;
        logic [8:0]  c;
        for (int i = 0; i < 4; i++) begin
            @(negedge brd_clk);
            d = {$urandom, $urandom};
            c = {1'b1, 1'($urandom), 1'(i == 3), 1'(i == bad_pos), 5'($urandom)};
            c[7] = (i == 3);
            brd_valid_i  = 1'b1;
            brd_ad_i     = d;
            brd_chk_i    = ref_par(d);
            brd_cmd_i    = c;
            brd_cmdpar_i = 1'($urandom);
            exp_cpu.push_back({d, ref_par(d) ^ {8{(bad_pos < 4) && (i >= bad_pos)}}, c, 1'b0});
        end
        @(negedge brd_clk);
        brd_valid_i = 1'b0;
        repeat ($urandom % 3) @(negedge brd_clk);
    endtask

    // Board-side monitor and ready driver.
    always @(negedge brd_clk) begin
        logic [81:0] e;
        logic [81:0] act;
        if (!brd_rst && !finished) begin
            if (brd_valid_o) begin
                act = {brd_ad_o, brd_chk_o, brd_cmd_o, brd_cmdpar_o};
                check((brd_cmd_o[8:7] == 2'b00) ? brd_rd_rdy_i : brd_wr_rdy_i,
                      "R5 beat issued without its ready", act, '0);
                if (exp_brd.size() == 0) begin
                    check(0, "R1 unexpected board beat", act, '0);
                end else begin
                    e = exp_brd.pop_front();
                    check({act[81:18], act[9:1]} == {e[81:18], e[9:1]}, "R1 board ad/cmd", act, e);
                    check(act[17:10] == e[17:10], "R2 board check bits", act, e);
                    check(act[0] == e[0], "R3 board command parity", act, e);
                end
            end
        end
        case (rdy_mode)
            1:       begin brd_rd_rdy_i <= 1'b0; brd_wr_rdy_i <= 1'b0; end
            2:       begin brd_rd_rdy_i <= 1'b0; brd_wr_rdy_i <= 1'b1; end
            default: begin brd_rd_rdy_i <= ($urandom % 4 != 0); brd_wr_rdy_i <= ($urandom % 4 != 0); end
        endcase
    end

    // Processor-side return monitor.
    always @(negedge cpu_clk) begin
        logic [81:0] e;
        logic [81:0] act;
        if (!cpu_rst && !finished && cpu_valid_o) begin
            act = {cpu_ad_o, cpu_chk_o, cpu_cmd_o, cpu_cmdpar_o};
            if (exp_cpu.size() == 0) begin
                check(0, "R7 unexpected return beat", act, '0);
            end else begin
                e = exp_cpu.pop_front();
                check({act[81:18], act[9:1]} == {e[81:18], e[9:1]}, "R7 return ad/cmd", act, e);
                check(act[17:10] == e[17:10], "R8 return check bits", act, e);
                check(act[0] == 1'b0, "R3 processor command parity", act, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge cpu_clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    task automatic cpu_stream(input int n);
        int r;
        for (int t = 0; t < n; t++) begin
            r = $urandom % 3;
            if (r == 0) begin
                send_beat({$urandom, $urandom}, 8'($urandom), {2'b00, 7'($urandom)}, ($urandom % 4 == 0));
            end else begin
                send_beat({$urandom, $urandom}, 8'($urandom), {2'b01, 7'($urandom)}, 1'b0);
                for (int k = 0; k < 1 + int'($urandom % 4); k++)
                    send_beat({$urandom, $urandom}, 8'($urandom), {1'b1, 8'($urandom)}, 1'b0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (6) @(negedge brd_clk);
        cpu_rst = 1'b0;
        brd_rst = 1'b0;
        @(negedge cpu_clk);
        // R9 reset state
        check(cpu_valid_o == 1'b0, "R9 cpu_valid_o after reset", 82'(cpu_valid_o), '0);
        check(brd_valid_o == 1'b0, "R9 brd_valid_o after reset", 82'(brd_valid_o), '0);
        check(cpu_full_o == 1'b0, "R9 cpu_full_o after reset", 82'(cpu_full_o), '0);

        // R4 directed: hit read dropped, following write kept
        send_beat(64'h0123_4567_89ab_cdef, 8'h00, 9'b0_0000_0011, 1'b1);
        send_beat(64'hfeed_face_0000_0001, 8'h00, 9'b0_1000_0001, 1'b0);
        repeat (40) @(negedge brd_clk);
        check(exp_brd.size() == 0, "R4 hit read dropped, write delivered", 82'(exp_brd.size()), '0);

        // R5 directed: read blocked at head holds back a write
        rdy_mode = 2;
        repeat (3) @(negedge brd_clk);
        send_beat(64'h1111_2222_3333_4444, 8'h00, 9'b0_0000_0101, 1'b0);
        send_beat(64'h5555_6666_7777_8888, 8'h00, 9'b0_1000_0101, 1'b0);
        repeat (20) @(negedge brd_clk);
        check(exp_brd.size() == 2, "R5 blocked read holds queue", 82'(exp_brd.size()), 82'd2);
        rdy_mode = 0;
        repeat (40) @(negedge brd_clk);
        check(exp_brd.size() == 0, "R5 queue drains once ready", 82'(exp_brd.size()), '0);

        // R6 directed: fill, check full, strobe one more while full
        rdy_mode = 1;
        repeat (3) @(negedge brd_clk);
        for (int i = 0; i < 8; i++)
            send_beat({32'habcd_0000, 32'(i)}, 8'h00, 9'b0_1000_0000, 1'b0);
        repeat (4) @(negedge cpu_clk);
        check(cpu_full_o == 1'b1, "R6 full after depth beats", 82'(cpu_full_o), 82'd1);
        cpu_valid_i = 1'b1;
        cpu_ad_i    = 64'hdead_beef_dead_beef;
        cpu_cmd_i   = 9'b0_1000_0000;
        @(negedge cpu_clk);
        cpu_valid_i = 1'b0;
        check(exp_brd.size() == 8, "R6 queue holds depth", 82'(exp_brd.size()), 82'd8);
        rdy_mode = 0;
        repeat (80) @(negedge brd_clk);
        check(exp_brd.size() == 0, "R6 only depth beats emerge", 82'(exp_brd.size()), '0);
        check(cpu_full_o == 1'b0, "R6 full clears after drain", 82'(cpu_full_o), '0);

        // R8 directed bursts: flag on beat 1, then a clean burst, then flag on last beat
        send_burst(1);
        send_burst(4);
        send_burst(3);
        send_burst(0);

        // Mixed random traffic in both directions
        fork
            cpu_stream(150);
            for (int b = 0; b < 40; b++) send_burst($urandom % 6);
        join

        repeat (300) @(negedge brd_clk);
        check(exp_brd.size() == 0, "R1 all board beats delivered", 82'(exp_brd.size()), '0);
        check(exp_cpu.size() == 0, "R7 all return beats delivered", 82'(exp_cpu.size()), '0);
        finish_run();
    end
endmodule